// File: doc/BRIEF.md
# Cascadable Reload Timer Chain

This block holds a row of narrow down-counting reload timers. Each one can run on its own, or several neighbours can be joined into one wider timer. Every timer has its own reload base, counter, count-source choice, run bit, interrupt enable and a square-wave output that flips on each underflow. A timer either advances on one of several prescaled tick inputs, or it takes its tick from the underflow carry of the timer just below it. Joining adjacent timers this way forms a single 16-, 24- or 32-bit reload timer. Its period follows the base bytes read together as one number, with the highest stage holding the most significant byte.

Software programs the block through a one-cycle write port. A byte write sets either one base or one control byte. A wide write sets the bases of an aligned even/odd pair in the same clock edge, so a joined pair can take a new period without a torn intermediate value. Only the highest stage of a joined group drives an interrupt or a square wave. The lower stages stay silent, and their interrupt enables have no effect.

Top module: `ctmr_cascade`

## Requirements
- R1: While reset is held, and after it until software writes, every interrupt and square-wave output is 0 and no timer counts.
- R2: A lone timer ticked every cycle with base B raises its interrupt pulse every B+1 cycles.
- R3: Control bits [1:0] pick the count source. Values 0, 1 and 2 select src_tick_i bit 0, 1 or 2. With a tick every k cycles, the period is k*(B+1) cycles.
- R4: When control bits [1:0] are 2'b11 on a higher stage, that stage advances only on the underflow of the stage below. A joined pair then has a period of ({base_hi, base_lo}+1) source ticks, so a 16-bit base of 0x1FFF gives 0x2000 ticks.
- R5: Three or four joined stages behave as one 24- or 32-bit timer. This includes a group whose lowest stage is an odd timer.
- R6: A stage whose upper neighbour is set to cascade raises no interrupt and holds its square wave at 0, even with its interrupt enable set.
- R7: The square-wave output of a group's highest stage inverts on each of its underflows.
- R8: Control bit 3 gates the interrupt. With it clear, no pulse is raised, but the square wave still toggles.
- R9: Writing a control byte with bit 4 set copies that stage's base into its counter at that edge. Bit 2 starts counting. The first pulse then appears B+1 clock edges after the write edge.
- R10: Selecting cascade (2'b11) on timer 0 leaves it stopped, with no interrupt.
- R11: A wide write to an even index loads that base from data[7:0] and the next base from data[15:8] in one edge. A wide write to an odd index changes nothing.
- R12: A base written while counting leaves the running interval as it is and sets the length of the following intervals. This holds for a single stage and for a pair written with one wide write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_tick_i | input | N_SRC | Prescaled count-source ticks, one cycle wide each |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | $clog2(N_TMR) | Timer index of the write |
| wr_ctrl_i | input | 1 | 1 selects the control byte, 0 the base |
| wr_wide_i | input | 1 | Paired base write (even index only) |
| wr_data_i | input | 2*TW | Write data; control: [1:0] source, [2] run, [3] irq enable, [4] load |
| irq_o | output | N_TMR | One-cycle interrupt pulse per timer |
| tout_o | output | N_TMR | Square-wave output per timer |

## Verification
A lone timer is swept over every base value on the every-cycle source, which separates off-by-one reload errors at each count. Selected bases on the every-third and every-fifth tick sources show that the source select routes the right input. Joined groups of two, three and four stages are tried with bases whose low bytes are zero, small or full. These tell a true concatenated period from a product of stage periods, and they expose a lower stage that reloads its base at every wrap. Writes made in the middle of an interval, the odd-index wide write, cascade on timer 0 and a cleared interrupt enable each show that the state the write could have disturbed is left untouched.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
    localparam int         SEL_W       = 2;
    localparam logic [1:0] SRC_CASCADE = 2'b11;
    localparam int         CB_RUN      = 2;
    localparam int         CB_IE       = 3;
    localparam int         CB_LOAD     = 4;
endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
    import ctmr_pkg::*;
#(
    parameter int N_TMR = 4,
    parameter int TW    = 8,
    localparam int IDX_W = $clog2(N_TMR)
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        wr_en_i,
    input  logic [IDX_W-1:0]            wr_idx_i,
    input  logic                        wr_ctrl_i,
    input  logic                        wr_wide_i,
    input  logic [2*TW-1:0]             wr_data_i,
    output logic [N_TMR-1:0][TW-1:0]    base_o,
    output logic [N_TMR-1:0][SEL_W-1:0] sel_o,
    output logic [N_TMR-1:0]            run_o,
    output logic [N_TMR-1:0]            ie_o,
    output logic [N_TMR-1:0]            load_o
);
    typedef struct packed {
        logic [N_TMR-1:0][TW-1:0]    base;
        logic [N_TMR-1:0][SEL_W-1:0] sel;
        logic [N_TMR-1:0]            run;
        logic [N_TMR-1:0]            ie;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic [IDX_W-1:0] odd_idx;

    assign odd_idx = {wr_idx_i[IDX_W-1:1], 1'b1};

    always_comb begin
        regs_d = regs_q;
        load_o = '0;
        if (wr_en_i) begin
            if (wr_ctrl_i) begin
                regs_d.sel[wr_idx_i] = wr_data_i[SEL_W-1:0];
                regs_d.run[wr_idx_i] = wr_data_i[CB_RUN];
                regs_d.ie[wr_idx_i]  = wr_data_i[CB_IE];
                load_o[wr_idx_i]     = wr_data_i[CB_LOAD];
            end else if (!wr_wide_i) begin
                regs_d.base[wr_idx_i] = wr_data_i[TW-1:0];
            end else if (!wr_idx_i[0] && (int'(odd_idx) < N_TMR)) begin
                regs_d.base[wr_idx_i] = wr_data_i[TW-1:0];
                regs_d.base[odd_idx]  = wr_data_i[2*TW-1:TW];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign base_o = regs_q.base;
    assign sel_o  = regs_q.sel;
    assign run_o  = regs_q.run;
    assign ie_o   = regs_q.ie;
endmodule

// File: rtl/ctmr_link.sv
module ctmr_link
    import ctmr_pkg::*;
#(
    parameter int N_TMR = 4,
    parameter int TW    = 8,
    parameter int N_SRC = 3
) (
    input  logic [N_TMR-1:0][TW-1:0]    cnt_i,
    input  logic [N_TMR-1:0][SEL_W-1:0] sel_i,
    input  logic [N_TMR-1:0]            run_i,
    input  logic [N_SRC-1:0]            src_tick_i,
    output logic [N_TMR-1:0]            adv_o,
    output logic [N_TMR-1:0]            uf_o,
    output logic [N_TMR-1:0]            top_o,
    output logic [N_TMR-1:0]            rel_o
);
    logic carry;
    logic tk;

    // carry ripples upward; stage 0 on cascade sees no carry and stays idle
    always_comb begin
        carry = 1'b0;
        for (int i = 0; i < N_TMR; i++) begin
            tk = 1'b0;
            if (sel_i[i] == SRC_CASCADE) begin
                tk = carry;
            end else begin
                for (int s = 0; s < N_SRC; s++) begin
                    if (sel_i[i] == SEL_W'(s)) tk = src_tick_i[s];
                end
            end
            adv_o[i] = run_i[i] & tk;
            uf_o[i]  = adv_o[i] & (cnt_i[i] == '0);
            carry    = uf_o[i];
        end
    end

    // group top detection and group-wide reload travel downward
    always_comb begin
        top_o[N_TMR-1] = 1'b1;
        rel_o[N_TMR-1] = uf_o[N_TMR-1];
        for (int i = N_TMR - 2; i >= 0; i--) begin
            top_o[i] = (sel_i[i+1] != SRC_CASCADE);
            rel_o[i] = top_o[i] ? uf_o[i] : rel_o[i+1];
        end
    end
endmodule

// File: rtl/ctmr_counters.sv
module ctmr_counters #(
    parameter int N_TMR = 4,
    parameter int TW    = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [N_TMR-1:0][TW-1:0] base_i,
    input  logic [N_TMR-1:0]         load_i,
    input  logic [N_TMR-1:0]         ie_i,
    input  logic [N_TMR-1:0]         adv_i,
    input  logic [N_TMR-1:0]         uf_i,
    input  logic [N_TMR-1:0]         top_i,
    input  logic [N_TMR-1:0]         rel_i,
    output logic [N_TMR-1:0][TW-1:0] cnt_o,
    output logic [N_TMR-1:0]         irq_o,
    output logic [N_TMR-1:0]         tout_o
);
    typedef struct packed {
        logic [N_TMR-1:0][TW-1:0] cnt;
        logic [N_TMR-1:0]         tout;
        logic [N_TMR-1:0]         irq;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_TMR; i++) begin
            if (load_i[i]) begin
                st_d.cnt[i] = base_i[i];
            end else if (adv_i[i]) begin
                if (st_q.cnt[i] == '0) st_d.cnt[i] = rel_i[i] ? base_i[i] : '1;
                else                   st_d.cnt[i] = st_q.cnt[i] - 1'b1;
            end
            if (!top_i[i])     st_d.tout[i] = 1'b0;
            else if (uf_i[i])  st_d.tout[i] = ~st_q.tout[i];
            st_d.irq[i] = uf_i[i] & top_i[i] & ie_i[i];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign irq_o  = st_q.irq;
    assign tout_o = st_q.tout;
endmodule

// File: rtl/ctmr_cascade.sv
module ctmr_cascade
    import ctmr_pkg::*;
#(
    parameter int N_TMR = 4,
    parameter int TW    = 8,
    parameter int N_SRC = 3,
    localparam int IDX_W = $clog2(N_TMR)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] src_tick_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_ctrl_i,
    input  logic             wr_wide_i,
    input  logic [2*TW-1:0]  wr_data_i,
    output logic [N_TMR-1:0] irq_o,
    output logic [N_TMR-1:0] tout_o
);
    logic [N_TMR-1:0][TW-1:0]    base_w, cnt_w;
    logic [N_TMR-1:0][SEL_W-1:0] sel_w;
    logic [N_TMR-1:0]            run_w, ie_w, load_w;
    logic [N_TMR-1:0]            adv_w, uf_w, top_w, rel_w;

    ctmr_regs #(.N_TMR(N_TMR), .TW(TW)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .wr_ctrl_i (wr_ctrl_i),
        .wr_wide_i (wr_wide_i),
        .wr_data_i (wr_data_i),
        .base_o    (base_w),
        .sel_o     (sel_w),
        .run_o     (run_w),
        .ie_o      (ie_w),
        .load_o    (load_w)
    );

    ctmr_link #(.N_TMR(N_TMR), .TW(TW), .N_SRC(N_SRC)) u_link (
        .cnt_i      (cnt_w),
        .sel_i      (sel_w),
        .run_i      (run_w),
        .src_tick_i (src_tick_i),
        .adv_o      (adv_w),
        .uf_o       (uf_w),
        .top_o      (top_w),
        .rel_o      (rel_w)
    );

    ctmr_counters #(.N_TMR(N_TMR), .TW(TW)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .base_i (base_w),
        .load_i (load_w),
        .ie_i   (ie_w),
        .adv_i  (adv_w),
        .uf_i   (uf_w),
        .top_i  (top_w),
        .rel_i  (rel_w),
        .cnt_o  (cnt_w),
        .irq_o  (irq_o),
        .tout_o (tout_o)
    );
endmodule

// File: rtl/ctmr_cascade_chk.sv
module ctmr_cascade_chk #(
    parameter int N_TMR = 4
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [N_TMR-1:0]       irq_o,
    input logic [N_TMR-1:0]       tout_o,
    input logic [N_TMR-1:0][1:0]  sel_w,
    input logic [N_TMR-1:0]       ie_w
);
    // R1: outputs quiet coming out of reset
    a_r1_quiet_reset: assert property (@(posedge clk_i)
        !rst_ni |=> (irq_o == '0 && tout_o == '0));

    for (genvar g = 0; g < N_TMR; g++) begin : g_chk
        // R8: cleared enable blocks the pulse
        a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !ie_w[g] |=> !irq_o[g]);
        // R7: every pulse comes with a flip of the square wave
        a_r7_pulse_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[g] |-> (tout_o[g] != $past(tout_o[g])));
        if (g < N_TMR - 1) begin : g_low
            // R6: a stage under a cascading neighbour stays silent
            a_r6_lower_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (sel_w[g+1] == 2'b11) |=> (!irq_o[g] && !tout_o[g]));
        end
        if (g == 0) begin : g_t0
            // R10: timer 0 on cascade never fires
            a_r10_t0_cascade_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (sel_w[0] == 2'b11) |=> !irq_o[0]);
        end
    end
endmodule

bind ctmr_cascade ctmr_cascade_chk #(.N_TMR(N_TMR)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_o  (irq_o),
    .tout_o (tout_o),
    .sel_w  (sel_w),
    .ie_w   (ie_w)
);

// File: tb/tb_ctmr_cascade.sv
module tb_ctmr_cascade;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src = 3'b001;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic        wr_ctrl = 1'b0;
    logic        wr_wide = 1'b0;
    logic [15:0] wr_data = '0;
    logic [3:0]  irq, tout;
    int          nvec = 0;
    int          nfail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    ctmr_cascade dut (
        .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src), .wr_en_i(wr_en),
        .wr_idx_i(wr_idx), .wr_ctrl_i(wr_ctrl), .wr_wide_i(wr_wide),
        .wr_data_i(wr_data), .irq_o(irq), .tout_o(tout)
    );

    // tick sources: bit0 every cycle, bit1 every 3rd, bit2 every 5th
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            src[1] = (cyc % 3 == 0);
            src[2] = (cyc % 5 == 0);
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] cb(input logic [1:0] s, input bit run, input bit ie, input bit ld);
        return {11'b0, ld, ie, run, s};
    endfunction

    task automatic wr(input int idx, input bit ctl, input bit wide, input logic [15:0] d);
        wr_en = 1'b1; wr_idx = idx[1:0]; wr_ctrl = ctl; wr_wide = wide; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_wide = 1'b0; wr_ctrl = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic single(input int idx, input int b, input logic [1:0] s);
        wr(idx, 0, 0, 16'(b));
        wr(idx, 1, 0, cb(s, 1, 1, 1));
    endtask

    // waits for a pulse, then measures cycles to the next pulse
    task automatic measure(input int idx, input int expv, input logic [3:0] mask, input string tag);
        int   c = 0;
        int   bad = 0;
        logic t0v;
        while (!irq[idx] && c < 2 * expv + 50) begin @(negedge clk); c++; end
        t0v = tout[idx];
        c = 0;
        do begin
            @(negedge clk);
            c++;
            if (((irq | tout) & mask) != 0) bad++;
        end while (!irq[idx] && c < 2 * expv + 50);
        chk(c == expv, tag, c, expv);
        chk(tout[idx] != t0v, "R7 toggle per underflow", tout[idx], !t0v);
        if (mask != 0) chk(bad == 0, "R6 lower stage silent", bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int c;
        int tg;
        int bad;
        logic pt;
        // R1
        do_reset();
        chk(irq == 0, "R1 irq after reset", irq, 0);
        chk(tout == 0, "R1 tout after reset", tout, 0);
        repeat (20) @(negedge clk);
        chk((irq | tout) == 0, "R1 idle without writes", irq | tout, 0);

        // R9: first pulse exactly B+1 edges after load write
        wr(0, 0, 0, 16'd5);
        wr(0, 1, 0, cb(2'd0, 1, 1, 1));
        bad = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k < 6 && irq[0]) bad++;
        end
        chk(bad == 0 && irq[0], "R9 load then first pulse", {bad, irq[0]}, 1);

        // R2: full base sweep, every-cycle source
        for (int b = 0; b < 256; b++) begin
            single(0, b, 2'd0);
            measure(0, b + 1, 4'b0, "R2 lone period");
        end

        // R3: other sources
        foreach (src[s]) begin
            int bs[4] = '{0, 7, 100, 255};
            foreach (bs[j]) begin
                single(0, bs[j], 2'(s));
                measure(0, (s == 0 ? 1 : (s == 1 ? 3 : 5)) * (bs[j] + 1), 4'b0, "R3 source select");
            end
        end

        // R8: enable clear, square wave still toggles
        do_reset();
        wr(0, 0, 0, 16'd3);
        wr(0, 1, 0, cb(2'd0, 1, 0, 1));
        tg = 0; bad = 0; pt = tout[0];
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (irq[0]) bad++;
            if (tout[0] != pt) tg++;
            pt = tout[0];
        end
        chk(bad == 0, "R8 no pulse when disabled", bad, 0);
        chk(tg == 10, "R8 tout toggles when disabled", tg, 10);

        // R10: cascade on timer 0
        do_reset();
        wr(0, 0, 0, 16'd2);
        wr(0, 1, 0, cb(2'b11, 1, 1, 1));
        bad = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (irq[0] || tout[0]) bad++;
        end
        chk(bad == 0, "R10 timer0 cascade stopped", bad, 0);

        // R4 / R11 / R6: 16-bit pair via wide write
        do_reset();
        wr(0, 0, 1, 16'h1FFF);
        wr(1, 1, 0, cb(2'b11, 1, 1, 1));
        wr(0, 1, 0, cb(2'd0, 1, 1, 1));
        measure(1, 16'h2000, 4'b0001, "R4 R11 16-bit 0x1FFF");
        wr(0, 0, 1, 16'h0100);
        wr(1, 1, 0, cb(2'b11, 1, 1, 1));
        wr(0, 1, 0, cb(2'd1, 1, 1, 1));
        measure(1, 3 * 16'h0101, 4'b0001, "R4 16-bit 0x0100 src1");
        wr(0, 0, 1, 16'h0000);
        wr(1, 1, 0, cb(2'b11, 1, 1, 1));
        wr(0, 1, 0, cb(2'd0, 1, 1, 1));
        measure(1, 1, 4'b0001, "R4 16-bit zero base");
        // R11: odd wide write ignored
        wr(0, 0, 1, 16'h0100);
        wr(1, 0, 1, 16'h0302);
        wr(1, 1, 0, cb(2'b11, 1, 1, 1));
        wr(0, 1, 0, cb(2'd0, 1, 1, 1));
        measure(1, 16'h0101, 4'b0001, "R11 odd wide write ignored");

        // R12: pair rewritten atomically while counting
        wr(0, 0, 1, 16'h0030);
        wr(1, 1, 0, cb(2'b11, 1, 1, 1));
        wr(0, 1, 0, cb(2'd0, 1, 1, 1));
        measure(1, 16'h0031, 4'b0001, "R12 pair before rewrite");
        wr(0, 0, 1, 16'h0105);
        c = 1;
        while (!irq[1] && c < 200) begin @(negedge clk); c++; end
        chk(c == 16'h0031, "R12 pair current interval kept", c, 16'h0031);
        measure(1, 16'h0106, 4'b0001, "R12 pair new period");

        // R5: 32-bit group
        do_reset();
        wr(0, 0, 1, 16'h0102);
        wr(2, 0, 1, 16'h0000);
        wr(3, 1, 0, cb(2'b11, 1, 1, 1));
        wr(2, 1, 0, cb(2'b11, 1, 1, 1));
        wr(1, 1, 0, cb(2'b11, 1, 1, 1));
        wr(0, 1, 0, cb(2'd0, 1, 1, 1));
        measure(3, 259, 4'b0111, "R5 32-bit group");

        // R5: 24-bit group starting at odd timer 1, timer 0 alone
        do_reset();
        wr(3, 0, 0, 16'h00);
        wr(2, 0, 0, 16'h01);
        wr(1, 0, 0, 16'h05);
        wr(3, 1, 0, cb(2'b11, 1, 1, 1));
        wr(2, 1, 0, cb(2'b11, 1, 1, 1));
        wr(1, 1, 0, cb(2'd0, 1, 1, 1));
        single(0, 9, 2'd0);
        measure(3, 16'h0106, 4'b0110, "R5 24-bit unaligned group");
        measure(0, 10, 4'b0, "R5 neighbour stays independent");

        // R12: single stage base change mid-interval
        do_reset();
        single(0, 20, 2'd0);
        measure(0, 21, 4'b0, "R12 lone before rewrite");
        wr(0, 0, 0, 16'd6);
        c = 1;
        while (!irq[0] && c < 100) begin @(negedge clk); c++; end
        chk(c == 21, "R12 lone current interval kept", c, 21);
        measure(0, 7, 4'b0, "R12 lone new period");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule